// File: doc/BRIEF.md
# Soft-start and fault supervisor

This block is the digital sequencer of a multi-phase buck controller. It holds the phase drivers in high impedance until the supply monitor reports good power and the converter is enabled. It then runs a soft-start window that lasts a fixed number of switching cycles, handing a linearly rising reference value to the regulation loop, and after that lets the phases run freely.

Faults are handled here as well. An overcurrent flag causes hiccup recovery: the phases float for a delay equal to one soft-start window, then a new soft-start begins. An overvoltage compare sets a latch that only a power-on reset clears. While that latch is set, the phases alternate between a low-side clamp and high impedance, following the output level. A power-good output reflects an undervoltage flag with hysteresis and the overvoltage latch. Every asynchronous input passes through a two-flop synchronizer. The switching-cycle tick is a single-cycle pulse that is already synchronous to the clock.

Top module: `softstart_supervisor`

## Requirements
- R1: While the supply-good input or enable is low, and no overvoltage is latched, the phase mode is high impedance (2'b00) and the ramp is 0.
- R2: When supply-good and enable are both high, soft-start begins. The phase mode is run (2'b01) and the ramp starts at 0, then rises by one on each tick. After SS_CYCLES ticks the block is in steady run, with the ramp held at SS_CYCLES.
- R3: Dropping enable during soft-start or steady run puts the phases in high impedance and sets the ramp to 0. Raising enable again starts a new soft-start from 0.
- R4: An overcurrent in steady run puts the phases in high impedance. They stay there for SS_CYCLES ticks, and then a new soft-start begins with the ramp at 0.
- R5: An overcurrent during soft-start puts the phases in high impedance. The remaining ticks of the window then elapse, followed by a further SS_CYCLES ticks of delay, before soft-start is retried.
- R6: When the overvoltage compare rises, the latch is set and the mode becomes force-low (2'b10). The mode stays force-low until the below-nominal compare is seen, and then becomes high impedance. A new overvoltage compare returns it to force-low.
- R7: Once the overvoltage latch is set, toggling enable and sending ticks do not clear it, and power good stays low. Only supply-good going low clears the latch, and the block restarts through soft-start afterwards.
- R8: The undervoltage flag is set by the below-90% compare and cleared by the above-92% compare. It holds its value while neither compare is active. Power good is high only when both the undervoltage flag and the overvoltage latch are clear.
- R9: The undervoltage flag does not change the phase mode or the ramp.
- R10: A change on an asynchronous input reaches the outputs at the third rising clock edge after it is applied, and not before.
- R11: After reset the mode is high impedance, the ramp is 0 and power good is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok_i | input | 1 | Supply monitor reports good power (asynchronous) |
| en_i | input | 1 | Converter enable (asynchronous) |
| tick_i | input | 1 | One-cycle pulse per switching cycle (synchronous) |
| oc_i | input | 1 | Overcurrent compare (asynchronous) |
| ov_trip_i | input | 1 | Output above the overvoltage threshold (asynchronous) |
| below_nom_i | input | 1 | Output below the nominal level (asynchronous) |
| below_uv_i | input | 1 | Output below 90% of the reference (asynchronous) |
| above_uvrel_i | input | 1 | Output above 92% of the reference (asynchronous) |
| mode_o | output | 2 | Phase mode: 00 high impedance, 01 run, 10 force low |
| ramp_o | output | RAMP_W | Soft-start reference value |
| pgood_o | output | 1 | Power good |

## Verification
The hardest case to reach is an overcurrent that arrives partway through soft-start. The recovery time depends on how many ticks remain in the window when the fault is seen. The stimulus therefore sweeps the fault across every tick position of a small window, and checks the exact tick on which the retry begins. The overvoltage hysteresis is reached by moving the trip and below-nominal compares independently, and then toggling enable and sending ticks while the latch is held.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        MODE_TRI = 2'b00,
        MODE_RUN = 2'b01,
        MODE_LOW = 2'b10
    } phase_mode_t;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SOFT,
        ST_RUN,
        ST_OC_SS,
        ST_OC_WAIT,
        ST_OV
    } seq_state_t;

    localparam int unsigned N_ASYNC = 7;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = d_i;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign q_o = r_q.s2;
endmodule

// File: rtl/sup_uv_window.sv
module sup_uv_window (
    input  logic clk,
    input  logic rst_n,
    input  logic below_uv_i,
    input  logic above_uvrel_i,
    input  logic ov_latched_i,
    output logic pgood_o
);
    typedef struct packed {
        logic uv;
    } uv_t;

    uv_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (below_uv_i)         r_d.uv = 1'b1;
        else if (above_uvrel_i) r_d.uv = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{uv: 1'b1};
        else        r_q <= r_d;
    end

    assign pgood_o = !r_q.uv && !ov_latched_i;

    // R8
    uv_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.uv) |-> $past(below_uv_i));

    // R8
    uv_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.uv) |-> $past(above_uvrel_i && !below_uv_i));
endmodule

// File: rtl/sup_sequencer.sv
module sup_sequencer
    import sup_pkg::*;
#(
    parameter int unsigned SS_CYCLES = 2048,
    parameter int unsigned RAMP_W    = $clog2(SS_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_i,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              oc_i,
    input  logic              ov_trip_i,
    input  logic              below_nom_i,
    output logic [1:0]        mode_o,
    output logic [RAMP_W-1:0] ramp_o,
    output logic              ov_latched_o
);
    localparam int unsigned        CNT_W     = (SS_CYCLES > 2) ? $clog2(SS_CYCLES) : 1;
    localparam logic [CNT_W-1:0]   LAST      = CNT_W'(SS_CYCLES - 1);
    localparam logic [RAMP_W-1:0]  RAMP_FULL = RAMP_W'(SS_CYCLES);

    typedef struct packed {
        seq_state_t       st;
        logic [CNT_W-1:0] cnt;
        logic             clamp;
    } seq_t;

    seq_t r_d, r_q;
    logic wrap;

    assign wrap = tick_i && (r_q.cnt == LAST);

    always_comb begin
        r_d = r_q;
        if (!por_i) begin
            r_d.st    = ST_OFF;
            r_d.cnt   = '0;
            r_d.clamp = 1'b0;
        end else if (r_q.st == ST_OV) begin
            if (r_q.clamp && below_nom_i)     r_d.clamp = 1'b0;
            else if (!r_q.clamp && ov_trip_i) r_d.clamp = 1'b1;
        end else if (ov_trip_i) begin
            r_d.st    = ST_OV;
            r_d.cnt   = '0;
            r_d.clamp = 1'b1;
        end else if (!en_i) begin
            r_d.st  = ST_OFF;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_OFF: begin
                    r_d.st  = ST_SOFT;
                    r_d.cnt = '0;
                end
                ST_SOFT: begin
                    if (tick_i) r_d.cnt = wrap ? '0 : r_q.cnt + 1'b1;
                    if (wrap)      r_d.st = oc_i ? ST_OC_WAIT : ST_RUN;
                    else if (oc_i) r_d.st = ST_OC_SS;
                end
                ST_RUN: begin
                    if (oc_i) begin
                        r_d.st  = ST_OC_WAIT;
                        r_d.cnt = '0;
                    end
                end
                ST_OC_SS: begin
                    if (tick_i) r_d.cnt = wrap ? '0 : r_q.cnt + 1'b1;
                    if (wrap)   r_d.st  = ST_OC_WAIT;
                end
                ST_OC_WAIT: begin
                    if (tick_i) r_d.cnt = wrap ? '0 : r_q.cnt + 1'b1;
                    if (wrap)   r_d.st  = ST_SOFT;
                end
                default: begin
                    r_d.st  = ST_OFF;
                    r_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_OFF, cnt: '0, clamp: 1'b0};
        else        r_q <= r_d;
    end

    always_comb begin
        mode_o = MODE_TRI;
        ramp_o = '0;
        unique case (r_q.st)
            ST_SOFT: begin
                mode_o = MODE_RUN;
                ramp_o = RAMP_W'(r_q.cnt);
            end
            ST_RUN: begin
                mode_o = MODE_RUN;
                ramp_o = RAMP_FULL;
            end
            ST_OV:   mode_o = r_q.clamp ? MODE_LOW : MODE_TRI;
            default: mode_o = MODE_TRI;
        endcase
    end

    assign ov_latched_o = (r_q.st == ST_OV);

    // R7
    por_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !por_i |=> (!ov_latched_o && mode_o == MODE_TRI));

    // R7
    ov_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_latched_o && por_i) |=> ov_latched_o);

    // R6
    ov_entry_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov_latched_o) |-> (mode_o == MODE_LOW));

    // R2
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SOFT && tick_i && r_q.cnt != LAST && por_i && en_i
         && !oc_i && !ov_trip_i) |=> (ramp_o == $past(ramp_o) + RAMP_W'(1)));
endmodule

// File: rtl/softstart_supervisor.sv
module softstart_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned SS_CYCLES = 2048,
    parameter int unsigned RAMP_W    = $clog2(SS_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok_i,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              oc_i,
    input  logic              ov_trip_i,
    input  logic              below_nom_i,
    input  logic              below_uv_i,
    input  logic              above_uvrel_i,
    output logic [1:0]        mode_o,
    output logic [RAMP_W-1:0] ramp_o,
    output logic              pgood_o
);
    logic [N_ASYNC-1:0] raw, syn;
    logic               ov_latched;

    assign raw = {por_ok_i, en_i, oc_i, ov_trip_i, below_nom_i, below_uv_i, above_uvrel_i};

    sup_sync #(.W(N_ASYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    sup_sequencer #(.SS_CYCLES(SS_CYCLES), .RAMP_W(RAMP_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .por_i        (syn[6]),
        .en_i         (syn[5]),
        .tick_i       (tick_i),
        .oc_i         (syn[4]),
        .ov_trip_i    (syn[3]),
        .below_nom_i  (syn[2]),
        .mode_o       (mode_o),
        .ramp_o       (ramp_o),
        .ov_latched_o (ov_latched)
    );

    sup_uv_window u_uv (
        .clk           (clk),
        .rst_n         (rst_n),
        .below_uv_i    (syn[1]),
        .above_uvrel_i (syn[0]),
        .ov_latched_i  (ov_latched),
        .pgood_o       (pgood_o)
    );
endmodule

// File: tb/softstart_supervisor_test.sv
`timescale 1ns/1ps
module softstart_supervisor_test;
    localparam int SS = 8;
    localparam int RW = $clog2(SS + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic por = 0, en = 0, tick = 0, oc = 0, ovt = 0, bnom = 0, buv = 1, auv = 0;
    logic [1:0]    mode;
    logic [RW-1:0] ramp;
    logic          pg;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    softstart_supervisor #(.SS_CYCLES(SS)) uut (
        .clk(clk), .rst_n(rst_n), .por_ok_i(por), .en_i(en), .tick_i(tick),
        .oc_i(oc), .ov_trip_i(ovt), .below_nom_i(bnom), .below_uv_i(buv),
        .above_uvrel_i(auv), .mode_o(mode), .ramp_o(ramp), .pgood_o(pg)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 mode", mode, 0); chk("R11 ramp", ramp, 0); chk("R11 pgood", pg, 0);
        rst_n = 1'b1;
        por = 1; en = 0; settle();
        chk("R1 en low", mode, 0); chk("R1 ramp", ramp, 0);
        por = 0; en = 1; settle();
        chk("R1 por low", mode, 0);

        // R10 latency
        por = 1;
        repeat (2) @(negedge clk);
        chk("R10 before third edge", mode, 0);
        @(negedge clk);
        chk("R10 at third edge", mode, 1); chk("R2 ramp start", ramp, 0);

        // R2 ramp
        @(negedge clk);
        chk("R2 no tick hold", ramp, 0);
        for (int k = 1; k < SS; k++) begin
            ticks(1);
            chk("R2 ramp step", ramp, k); chk("R2 mode", mode, 1);
        end
        ticks(1);
        chk("R2 full ramp", ramp, SS); chk("R2 run mode", mode, 1);

        // R8 / R9 undervoltage window
        chk("R8 pgood low uv", pg, 0);
        buv = 0; auv = 1; settle();
        chk("R8 uv cleared", pg, 1);
        auv = 0; settle();
        chk("R8 uv hold", pg, 1);
        buv = 1; settle();
        chk("R8 uv set", pg, 0);
        chk("R9 mode", mode, 1); chk("R9 ramp", ramp, SS);
        buv = 0; settle();
        chk("R8 uv hold set", pg, 0);
        auv = 1; settle();
        chk("R8 uv recleared", pg, 1);

        // R4 hiccup from run
        oc = 1; settle();
        chk("R4 tri", mode, 0); chk("R4 ramp", ramp, 0);
        oc = 0;
        ticks(SS - 1);
        chk("R4 delay", mode, 0);
        ticks(1);
        chk("R4 restart mode", mode, 1); chk("R4 restart ramp", ramp, 0);

        // R5 sweep fault position inside soft-start
        for (int p = 0; p < SS; p++) begin
            ticks(p);
            chk("R5 ramp before fault", ramp, p);
            oc = 1; settle();
            chk("R5 tri", mode, 0);
            oc = 0;
            ticks((SS - p) + (SS - 1));
            chk("R5 still waiting", mode, 0);
            ticks(1);
            chk("R5 retry mode", mode, 1); chk("R5 retry ramp", ramp, 0);
        end
        ticks(SS);
        chk("R5 run after retry", ramp, SS);

        // R3 enable drop
        en = 0; settle();
        chk("R3 tri", mode, 0); chk("R3 ramp", ramp, 0);
        en = 1; settle();
        chk("R3 restart", mode, 1); chk("R3 ramp 0", ramp, 0);
        ticks(3);
        en = 0; settle();
        chk("R3 tri in soft", mode, 0);
        en = 1; settle();

        // R6 overvoltage clamp
        ovt = 1; settle();
        chk("R6 force low", mode, 2); chk("R6 pgood", pg, 0);
        ovt = 0; settle();
        chk("R6 low until nominal", mode, 2);
        bnom = 1; settle();
        chk("R6 tri below nominal", mode, 0);
        bnom = 0; settle();
        chk("R6 tri hold", mode, 0);
        ovt = 1; settle();
        chk("R6 retrip low", mode, 2);
        ovt = 0; bnom = 1; settle();
        chk("R6 release tri", mode, 0);

        // R7 latch persistence
        en = 0; settle();
        chk("R7 en low mode", mode, 0); chk("R7 en low pgood", pg, 0);
        en = 1; settle();
        chk("R7 en high mode", mode, 0); chk("R7 ramp", ramp, 0); chk("R7 pgood", pg, 0);
        ticks(SS + 2);
        chk("R7 ticks ignored", mode, 0);
        por = 0; settle();
        chk("R7 por low", mode, 0);
        por = 1; bnom = 0; settle();
        chk("R7 restart mode", mode, 1); chk("R7 restart ramp", ramp, 0);
        chk("R7 pgood back", pg, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule